// File: doc/BRIEF.md
# Audio DMA front end: register decoder and global control

This block sits in front of three audio DMA channel controllers (PCM capture, PCM playback, microphone capture) and turns byte, word and doubleword accesses on a 64-byte register window into per-channel write strobes and read data. The channel registers live in the channel controllers. This block presents their current values as inputs, and it drives a shared write-data bus with one strobe per writable field and channel.

The block holds the global control word, the codec-access semaphore byte and the global status word. Global control carries a cold-reset bit and a self-clearing warm-reset bit. While the cold-reset bit is 0, the whole window is write-locked, apart from a doubleword write to global control. Writing global control with the cold-reset bit clear sends a one-cycle reset pulse to every channel. A warm-reset request sends a one-cycle pulse only when neither the capture nor the playback stream is running. Global status mirrors the three channel interrupt lines, and a single level interrupt is the OR of them.

Top module: `acbm_front`

## Requirements
- R1: After reset, global control and the semaphore read 0, cold_o is 1, and no strobe or pulse is active.
- R2: While global control bit 1 is 0, any write other than a doubleword write to 0x2C raises no strobe and leaves the semaphore unchanged.
- R3: Channel blocks sit at 0x00, 0x10 and 0x20 (strobe bit index 0, 1, 2). A doubleword write at +0 raises the base strobe, a byte write at +5 the last-index strobe, a byte or word write at +6 the status strobe, and a byte write at +0xB the control strobe. ch_wdata_o carries the write data masked to the access width.
- R4: Writes at +4, +8 and +0xA, writes to 0x30, and writes with any other size at a writable offset raise no strobe.
- R5: Channel reads are as follows. Bytes at +4, +5, +6, +0xA and +0xB give the current index, last index, status low byte, prefetch index and control. Words at +6 and +8 give status and remaining samples. Doublewords at +0 and +4 give the base and {status[15:0], last index byte, current index byte}. Index values are zero-extended to 8 bits.
- R6: A read at any other offset, a read with any other size, and a non-read access all return 0.
- R7: A doubleword write to 0x2C with bit 1 clear stores the data ANDed with 0x70, clears the semaphore, and drives ch_rst_o to all ones for exactly the following cycle.
- R8: Bit 2 of global control always reads 0. A write of 0x76 reads back 0x72, and the other bits are stored as written.
- R9: A doubleword write to 0x2C with bits 1 and 2 set, while ch_run_i[1:0] is 0, gives a one-cycle warm_rst_o pulse in the following cycle and no ch_rst_o pulse.
- R10: A warm request has no effect while ch_run_i[0] or ch_run_i[1] is 1. ch_run_i[2] does not block it.
- R11: Global status (doubleword at 0x30) holds ch_irq_i in bits 7:5, with all other bits 0. irq_o is 1 exactly when any ch_irq_i bit is 1.
- R12: With the lock released, a byte write to 0x34 stores the semaphore, and a byte read at 0x34 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Register access this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 doubleword |
| acc_addr_i | input | 6 | Byte offset in the window |
| acc_wdata_i | input | 32 | Right-aligned write data |
| acc_rdata_o | output | 32 | Right-aligned read data, combinational |
| ch_base_i | input | 96 | Per-channel descriptor base |
| ch_civ_i | input | 15 | Per-channel current index |
| ch_lvi_i | input | 15 | Per-channel last valid index |
| ch_piv_i | input | 15 | Per-channel prefetch index |
| ch_sr_i | input | 48 | Per-channel status |
| ch_picb_i | input | 48 | Per-channel remaining samples |
| ch_cr_i | input | 24 | Per-channel control |
| ch_irq_i | input | 3 | Per-channel interrupt |
| ch_run_i | input | 3 | Per-channel running |
| ch_wdata_o | output | 32 | Write data for channel strobes |
| ch_base_we_o | output | 3 | Base write strobe |
| ch_lvi_we_o | output | 3 | Last-index write strobe |
| ch_sr_we_o | output | 3 | Status write strobe |
| ch_cr_we_o | output | 3 | Control write strobe |
| ch_rst_o | output | 3 | Channel reset pulse |
| warm_rst_o | output | 1 | Warm reset pulse |
| cold_o | output | 1 | Write lock (cold reset) active |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with its default parameters. These are 5-bit ring indices, a cold-reset keep mask of 0x70, interrupt status starting at bit 5, and warm reset blocked by channels 0 and 1. Because indices are 5 bits, the zero-extension of the byte and combined reads can be observed. The keep mask lets the R7 check tell stored bits from discarded ones. The blocking mask puts the microphone-running case, which must not block a warm reset, on the ports.

// File: rtl/acbm_pkg.sv
package acbm_pkg;
  localparam int NCH   = 3;
  localparam int ADR_W = 6;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_size_e;

  localparam logic [3:0] OFS_BASE = 4'h0;
  localparam logic [3:0] OFS_CIV  = 4'h4;
  localparam logic [3:0] OFS_LVI  = 4'h5;
  localparam logic [3:0] OFS_SR   = 4'h6;
  localparam logic [3:0] OFS_PICB = 4'h8;
  localparam logic [3:0] OFS_PIV  = 4'hA;
  localparam logic [3:0] OFS_CR   = 4'hB;

  localparam logic [ADR_W-1:0] ADR_GCTL = 6'h2C;
  localparam logic [ADR_W-1:0] ADR_GSTA = 6'h30;
  localparam logic [ADR_W-1:0] ADR_SEMA = 6'h34;

  localparam int GC_COLD_BIT = 1;
  localparam int GC_WARM_BIT = 2;

  typedef struct packed {
    logic [NCH-1:0] ch;
    logic [3:0]     sub;
    logic           gctl;
    logic           gsta;
    logic           sema;
  } dec_t;
endpackage

// File: rtl/acbm_decode.sv
module acbm_decode
  import acbm_pkg::*;
(
  input  logic [ADR_W-1:0] addr_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o.sub  = addr_i[3:0];
    dec_o.gctl = (addr_i == ADR_GCTL);
    dec_o.gsta = (addr_i == ADR_GSTA);
    dec_o.sema = (addr_i == ADR_SEMA);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // global control shares the top nibble of the last channel block
    assign dec_o.ch[c] = (addr_i[5:4] == 2'(c)) && (addr_i != ADR_GCTL);
  end
endmodule

// File: rtl/acbm_wr_route.sv
module acbm_wr_route
  import acbm_pkg::*;
(
  input  logic           wr_i,
  input  acc_size_e      size_i,
  input  logic [NCH-1:0] ch_hit_i,
  input  logic [3:0]     sub_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    wdata_o,
  output logic [NCH-1:0] base_we_o,
  output logic [NCH-1:0] lvi_we_o,
  output logic [NCH-1:0] sr_we_o,
  output logic [NCH-1:0] cr_we_o
);
  logic base_f, lvi_f, sr_f, cr_f;

  always_comb begin
    base_f = (sub_i == OFS_BASE) && (size_i == SZ_DWORD);
    lvi_f  = (sub_i == OFS_LVI)  && (size_i == SZ_BYTE);
    sr_f   = (sub_i == OFS_SR)   && ((size_i == SZ_BYTE) || (size_i == SZ_WORD));
    cr_f   = (sub_i == OFS_CR)   && (size_i == SZ_BYTE);
    unique case (size_i)
      SZ_BYTE:  wdata_o = {24'h0, wdata_i[7:0]};
      SZ_WORD:  wdata_o = {16'h0, wdata_i[15:0]};
      default:  wdata_o = wdata_i;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_stb
    logic sel;
    assign sel          = wr_i && ch_hit_i[c];
    assign base_we_o[c] = sel && base_f;
    assign lvi_we_o[c]  = sel && lvi_f;
    assign sr_we_o[c]   = sel && sr_f;
    assign cr_we_o[c]   = sel && cr_f;
  end
endmodule

// File: rtl/acbm_glob.sv
module acbm_glob
  import acbm_pkg::*;
#(
  parameter logic [31:0]    COLD_KEEP    = 32'h0000_0070,
  parameter int             GSTA_IRQ_LSB = 5,
  parameter logic [NCH-1:0] WARM_BLOCK   = 3'b011
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  acc_size_e      size_i,
  input  logic           gctl_hit_i,
  input  logic           sema_hit_i,
  input  logic [31:0]    wdata_i,
  input  logic [NCH-1:0] run_i,
  input  logic [NCH-1:0] irq_i,
  output logic [31:0]    gctl_o,
  output logic [7:0]     sema_o,
  output logic [31:0]    gsta_o,
  output logic           open_o,
  output logic [NCH-1:0] ch_rst_o,
  output logic           warm_o,
  output logic           irq_o
);
  localparam logic [31:0] RST_BITS  = (32'h1 << GC_COLD_BIT) | (32'h1 << GC_WARM_BIT);
  localparam logic [31:0] COLD_MASK = COLD_KEEP & ~RST_BITS;
  localparam logic [31:0] WARM_CLR  = ~(32'h1 << GC_WARM_BIT);

  logic gctl_wr, cold_req, warm_req, sema_wr;

  assign open_o = gctl_o[GC_COLD_BIT];

  always_comb begin
    gctl_wr  = wr_i && gctl_hit_i && (size_i == SZ_DWORD);
    cold_req = gctl_wr && !wdata_i[GC_COLD_BIT];
    warm_req = gctl_wr && wdata_i[GC_COLD_BIT] && wdata_i[GC_WARM_BIT]
               && ((run_i & WARM_BLOCK) == '0);
    sema_wr  = wr_i && open_o && sema_hit_i && (size_i == SZ_BYTE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_o   <= '0;
      sema_o   <= '0;
      ch_rst_o <= '0;
      warm_o   <= 1'b0;
    end else begin
      ch_rst_o <= {NCH{cold_req}};
      warm_o   <= warm_req;
      if (cold_req) begin
        gctl_o <= wdata_i & COLD_MASK;
        sema_o <= '0;
      end else if (gctl_wr) begin
        gctl_o <= wdata_i & WARM_CLR;
      end else if (sema_wr) begin
        sema_o <= wdata_i[7:0];
      end
    end
  end

  always_comb begin
    gsta_o = '0;
    gsta_o[GSTA_IRQ_LSB +: NCH] = irq_i;
  end
  assign irq_o = |gsta_o;
endmodule

// File: rtl/acbm_rd_mux.sv
module acbm_rd_mux
  import acbm_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               en_i,
  input  acc_size_e          size_i,
  input  dec_t               dec_i,
  input  logic [NCH*32-1:0]    base_i,
  input  logic [NCH*IDX_W-1:0] civ_i,
  input  logic [NCH*IDX_W-1:0] lvi_i,
  input  logic [NCH*IDX_W-1:0] piv_i,
  input  logic [NCH*16-1:0]    sr_i,
  input  logic [NCH*16-1:0]    picb_i,
  input  logic [NCH*8-1:0]     cr_i,
  input  logic [31:0]        gctl_i,
  input  logic [31:0]        gsta_i,
  input  logic [7:0]         sema_i,
  output logic [31:0]        rdata_o
);
  logic [31:0] ch_rd [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]  civ_b, lvi_b, piv_b, cr_b;
    logic [15:0] sr_w, picb_w;
    assign civ_b  = 8'(civ_i[c*IDX_W +: IDX_W]);
    assign lvi_b  = 8'(lvi_i[c*IDX_W +: IDX_W]);
    assign piv_b  = 8'(piv_i[c*IDX_W +: IDX_W]);
    assign cr_b   = cr_i[c*8 +: 8];
    assign sr_w   = sr_i[c*16 +: 16];
    assign picb_w = picb_i[c*16 +: 16];

    always_comb begin
      ch_rd[c] = '0;
      if (dec_i.ch[c]) begin
        unique case (size_i)
          SZ_BYTE: begin
            case (dec_i.sub)
              OFS_CIV: ch_rd[c] = {24'h0, civ_b};
              OFS_LVI: ch_rd[c] = {24'h0, lvi_b};
              OFS_SR:  ch_rd[c] = {24'h0, sr_w[7:0]};
              OFS_PIV: ch_rd[c] = {24'h0, piv_b};
              OFS_CR:  ch_rd[c] = {24'h0, cr_b};
              default: ch_rd[c] = '0;
            endcase
          end
          SZ_WORD: begin
            case (dec_i.sub)
              OFS_SR:   ch_rd[c] = {16'h0, sr_w};
              OFS_PICB: ch_rd[c] = {16'h0, picb_w};
              default:  ch_rd[c] = '0;
            endcase
          end
          SZ_DWORD: begin
            case (dec_i.sub)
              OFS_BASE: ch_rd[c] = base_i[c*32 +: 32];
              OFS_CIV:  ch_rd[c] = {sr_w, lvi_b, civ_b};
              default:  ch_rd[c] = '0;
            endcase
          end
          default: ch_rd[c] = '0;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (en_i) begin
      if (dec_i.gctl && size_i == SZ_DWORD) rdata_o = gctl_i;
      if (dec_i.gsta && size_i == SZ_DWORD) rdata_o = gsta_i;
      if (dec_i.sema && size_i == SZ_BYTE)  rdata_o = {24'h0, sema_i};
      for (int c = 0; c < NCH; c++) rdata_o = rdata_o | ch_rd[c];
    end
  end
endmodule

// File: rtl/acbm_front.sv
module acbm_front
  import acbm_pkg::*;
#(
  parameter int             IDX_W        = 5,
  parameter logic [31:0]    COLD_KEEP    = 32'h0000_0070,
  parameter int             GSTA_IRQ_LSB = 5,
  parameter logic [NCH-1:0] WARM_BLOCK   = 3'b011
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [1:0]           acc_size_i,
  input  logic [ADR_W-1:0]     acc_addr_i,
  input  logic [31:0]          acc_wdata_i,
  output logic [31:0]          acc_rdata_o,
  input  logic [NCH*32-1:0]    ch_base_i,
  input  logic [NCH*IDX_W-1:0] ch_civ_i,
  input  logic [NCH*IDX_W-1:0] ch_lvi_i,
  input  logic [NCH*IDX_W-1:0] ch_piv_i,
  input  logic [NCH*16-1:0]    ch_sr_i,
  input  logic [NCH*16-1:0]    ch_picb_i,
  input  logic [NCH*8-1:0]     ch_cr_i,
  input  logic [NCH-1:0]       ch_irq_i,
  input  logic [NCH-1:0]       ch_run_i,
  output logic [31:0]          ch_wdata_o,
  output logic [NCH-1:0]       ch_base_we_o,
  output logic [NCH-1:0]       ch_lvi_we_o,
  output logic [NCH-1:0]       ch_sr_we_o,
  output logic [NCH-1:0]       ch_cr_we_o,
  output logic [NCH-1:0]       ch_rst_o,
  output logic                 warm_rst_o,
  output logic                 cold_o,
  output logic                 irq_o
);
  dec_t        dec;
  acc_size_e   size;
  logic        wr, open;
  logic [31:0] gctl, gsta;
  logic [7:0]  sema;

  assign size   = acc_size_e'(acc_size_i);
  assign wr     = acc_valid_i && acc_write_i;
  assign cold_o = !open;

  acbm_decode u_dec (.addr_i(acc_addr_i), .dec_o(dec));

  acbm_wr_route u_wr (
    .wr_i     (wr && open),
    .size_i   (size),
    .ch_hit_i (dec.ch),
    .sub_i    (dec.sub),
    .wdata_i  (acc_wdata_i),
    .wdata_o  (ch_wdata_o),
    .base_we_o(ch_base_we_o),
    .lvi_we_o (ch_lvi_we_o),
    .sr_we_o  (ch_sr_we_o),
    .cr_we_o  (ch_cr_we_o)
  );

  acbm_glob #(
    .COLD_KEEP(COLD_KEEP), .GSTA_IRQ_LSB(GSTA_IRQ_LSB), .WARM_BLOCK(WARM_BLOCK)
  ) u_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .size_i    (size),
    .gctl_hit_i(dec.gctl),
    .sema_hit_i(dec.sema),
    .wdata_i   (acc_wdata_i),
    .run_i     (ch_run_i),
    .irq_i     (ch_irq_i),
    .gctl_o    (gctl),
    .sema_o    (sema),
    .gsta_o    (gsta),
    .open_o    (open),
    .ch_rst_o  (ch_rst_o),
    .warm_o    (warm_rst_o),
    .irq_o     (irq_o)
  );

  acbm_rd_mux #(.IDX_W(IDX_W)) u_rd (
    .en_i   (acc_valid_i && !acc_write_i),
    .size_i (size),
    .dec_i  (dec),
    .base_i (ch_base_i),
    .civ_i  (ch_civ_i),
    .lvi_i  (ch_lvi_i),
    .piv_i  (ch_piv_i),
    .sr_i   (ch_sr_i),
    .picb_i (ch_picb_i),
    .cr_i   (ch_cr_i),
    .gctl_i (gctl),
    .gsta_i (gsta),
    .sema_i (sema),
    .rdata_o(acc_rdata_o)
  );
endmodule

// File: rtl/acbm_front_chk.sv
module acbm_front_chk
  import acbm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_write_i,
  input logic [1:0]       acc_size_i,
  input logic [ADR_W-1:0] acc_addr_i,
  input logic [31:0]      acc_rdata_o,
  input logic [NCH-1:0]   ch_irq_i,
  input logic [NCH-1:0]   ch_run_i,
  input logic [NCH-1:0]   ch_base_we_o,
  input logic [NCH-1:0]   ch_lvi_we_o,
  input logic [NCH-1:0]   ch_sr_we_o,
  input logic [NCH-1:0]   ch_cr_we_o,
  input logic [NCH-1:0]   ch_rst_o,
  input logic             warm_rst_o,
  input logic             cold_o,
  input logic             irq_o
);
  logic [4*NCH-1:0] stb;
  assign stb = {ch_base_we_o, ch_lvi_we_o, ch_sr_we_o, ch_cr_we_o};

  a_r2_locked_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_o |-> (stb == '0));

  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb));

  a_r7_pulse_leaves_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_rst_o != '0) |-> (cold_o && ch_rst_o == '1));

  a_r7_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_rst_o != '0) |=> (ch_rst_o == '0) || $past(acc_valid_i && acc_write_i));

  a_r8_warm_bit_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && acc_addr_i == ADR_GCTL && acc_size_i == 2'd2)
      |-> !acc_rdata_o[GC_WARM_BIT]);

  a_r10_warm_not_while_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> ($past(ch_run_i[1:0]) == 2'b00));

  a_r9_warm_excludes_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> (ch_rst_o == '0));

  a_r11_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ch_irq_i != '0));
endmodule

bind acbm_front acbm_front_chk u_chk (.*);

// File: tb/acbm_front_test.sv
module acbm_front_test;
  localparam int NCH = 3;
  localparam int IW  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [1:0]  acc_size = 0;
  logic [5:0]  acc_addr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic [NCH*32-1:0] ch_base = 0;
  logic [NCH*IW-1:0] ch_civ = 0, ch_lvi = 0, ch_piv = 0;
  logic [NCH*16-1:0] ch_sr = 0, ch_picb = 0;
  logic [NCH*8-1:0]  ch_cr = 0;
  logic [NCH-1:0] ch_irq = 0, ch_run = 0;
  logic [31:0] ch_wdata;
  logic [NCH-1:0] base_we, lvi_we, sr_we, cr_we, ch_rst;
  logic warm_rst, cold, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_gctl = 0;
  logic [7:0]  m_sema = 0;

  always #4 clk = ~clk;

  acbm_front uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_size_i(acc_size), .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .ch_base_i(ch_base), .ch_civ_i(ch_civ), .ch_lvi_i(ch_lvi),
    .ch_piv_i(ch_piv), .ch_sr_i(ch_sr), .ch_picb_i(ch_picb), .ch_cr_i(ch_cr),
    .ch_irq_i(ch_irq), .ch_run_i(ch_run), .ch_wdata_o(ch_wdata),
    .ch_base_we_o(base_we), .ch_lvi_we_o(lvi_we), .ch_sr_we_o(sr_we), .ch_cr_we_o(cr_we),
    .ch_rst_o(ch_rst), .warm_rst_o(warm_rst), .cold_o(cold), .irq_o(irq)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_stb(input logic w, input logic [1:0] sz,
                                          input logic [5:0] a);
    logic [11:0] s = '0;
    int c = int'(a[5:4]);
    logic [3:0] o = a[3:0];
    if (w && m_gctl[1] && c < NCH && a != 6'h2C) begin
      if (o == 4'h0 && sz == 2)              s[9+c] = 1'b1;
      if (o == 4'h5 && sz == 0)              s[6+c] = 1'b1;
      if (o == 4'h6 && (sz == 0 || sz == 1)) s[3+c] = 1'b1;
      if (o == 4'hB && sz == 0)              s[c]   = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [5:0] a);
    int c = int'(a[5:4]);
    logic [3:0] o = a[3:0];
    logic [7:0] civ8, lvi8, piv8;
    logic [15:0] sr;
    if (a == 6'h2C) return (sz == 2) ? m_gctl : 32'h0;
    if (a == 6'h30) return (sz == 2) ? (32'(ch_irq) << 5) : 32'h0;
    if (a == 6'h34) return (sz == 0) ? {24'h0, m_sema} : 32'h0;
    if (c >= NCH) return 32'h0;
    civ8 = 8'(ch_civ[c*IW +: IW]);
    lvi8 = 8'(ch_lvi[c*IW +: IW]);
    piv8 = 8'(ch_piv[c*IW +: IW]);
    sr   = ch_sr[c*16 +: 16];
    if (sz == 0) begin
      if (o == 4'h4) return {24'h0, civ8};
      if (o == 4'h5) return {24'h0, lvi8};
      if (o == 4'h6) return {24'h0, sr[7:0]};
      if (o == 4'hA) return {24'h0, piv8};
      if (o == 4'hB) return {24'h0, ch_cr[c*8 +: 8]};
    end else if (sz == 1) begin
      if (o == 4'h6) return {16'h0, sr};
      if (o == 4'h8) return {16'h0, ch_picb[c*16 +: 16]};
    end else if (sz == 2) begin
      if (o == 4'h0) return ch_base[c*32 +: 32];
      if (o == 4'h4) return {sr, lvi8, civ8};
    end
    return 32'h0;
  endfunction

  task automatic shuffle_ch();
    for (int c = 0; c < NCH; c++) begin
      ch_base[c*32 +: 32] = $urandom;
      ch_civ[c*IW +: IW]  = IW'($urandom);
      ch_lvi[c*IW +: IW]  = IW'($urandom);
      ch_piv[c*IW +: IW]  = IW'($urandom);
      ch_sr[c*16 +: 16]   = 16'($urandom);
      ch_picb[c*16 +: 16] = 16'($urandom);
      ch_cr[c*8 +: 8]     = 8'($urandom);
    end
    ch_irq = 3'($urandom);
    ch_run = 3'($urandom);
  endtask

  task automatic acc(input logic v, input logic w, input logic [1:0] sz,
                     input logic [5:0] a, input logic [31:0] d);
    logic [11:0] es, as;
    logic [31:0] ew, er;
    logic [2:0]  erst;
    logic        ewarm;
    string       tg;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_size = sz; acc_addr = a; acc_wdata = d;
    #1;
    es = v ? exp_stb(w, sz, a) : 12'h0;
    as = {base_we, lvi_we, sr_we, cr_we};
    tg = (w && !m_gctl[1]) ? "R2 locked write" : ((w && es == 0) ? "R4 no strobe" : "R3 strobe");
    check(as == es, tg, 32'(as), 32'(es));
    if (es != 0) begin
      ew = (sz == 0) ? {24'h0, d[7:0]} : (sz == 1) ? {16'h0, d[15:0]} : d;
      check(ch_wdata == ew, "R3 write data", ch_wdata, ew);
    end
    er = (v && !w) ? exp_rd(sz, a) : 32'h0;
    if (a == 6'h30) tg = "R11 status";
    else if (a == 6'h34) tg = "R12 semaphore";
    else if (a == 6'h2C) tg = "R8 global control";
    else if (a[5:4] != 2'd3 && v && !w) tg = "R5 channel read";
    else tg = "R6 zero read";
    check(acc_rdata == er, tg, acc_rdata, er);
    check(irq == (ch_irq != 0), "R11 irq line", 32'(irq), 32'(ch_irq != 0));
    erst = 3'b000; ewarm = 1'b0;
    if (v && w && a == 6'h2C && sz == 2) begin
      if (!d[1]) begin
        m_gctl = d & 32'h70; m_sema = 8'h0; erst = 3'b111;
      end else begin
        m_gctl = d & ~32'h4;
        ewarm = d[2] && ch_run[1:0] == 2'b00;
      end
    end else if (v && w && a == 6'h34 && sz == 0 && m_gctl[1]) begin
      m_sema = d[7:0];
    end
    @(posedge clk); #1;
    check(ch_rst == erst, "R7 channel reset pulse", 32'(ch_rst), 32'(erst));
    check(warm_rst == ewarm, "R9 R10 warm pulse", 32'(warm_rst), 32'(ewarm));
    check(cold == !m_gctl[1], "R7 lock state", 32'(cold), 32'(!m_gctl[1]));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    shuffle_ch();
    ch_run = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cold == 1'b1, "R1 lock after reset", 32'(cold), 32'h1);
    check({ch_rst, warm_rst} == 4'h0, "R1 no pulse", 32'({ch_rst, warm_rst}), 32'h0);
    acc(1, 0, 2, 6'h2C, 0);
    acc(1, 0, 0, 6'h34, 0);
    // R2 locked writes dropped
    acc(1, 1, 0, 6'h34, 32'hA5);
    acc(1, 1, 0, 6'h1B, 32'h01);
    acc(1, 1, 2, 6'h00, 32'h1234_5678);
    acc(1, 0, 0, 6'h34, 0);
    // unlock, R8 warm bit self-clears; R9 pulse with streams idle
    acc(1, 1, 2, 6'h2C, 32'h76);
    acc(1, 0, 2, 6'h2C, 0);
    r = acc_rdata;
    check(r == 32'h72, "R8 readback 0x76", r, 32'h72);
    acc(1, 1, 2, 6'h2C, 32'h72);
    // R12 semaphore
    acc(1, 1, 0, 6'h34, 32'h5C);
    acc(1, 0, 0, 6'h34, 0);
    // R10 blocked by playback, not by microphone
    ch_run = 3'b010; acc(1, 1, 2, 6'h2C, 32'h76);
    ch_run = 3'b001; acc(1, 1, 2, 6'h2C, 32'h76);
    ch_run = 3'b100; acc(1, 1, 2, 6'h2C, 32'h76);
    ch_run = 3'b000;
    // R4 read-only offsets
    acc(1, 1, 0, 6'h14, 32'hFF);
    acc(1, 1, 1, 6'h28, 32'hFFFF);
    acc(1, 1, 0, 6'h0A, 32'hFF);
    acc(1, 1, 2, 6'h30, 32'hFFFF_FFFF);
    acc(1, 1, 1, 6'h05, 32'hFFFF);
    // R6 unmapped
    acc(1, 0, 2, 6'h3C, 0);
    acc(1, 0, 1, 6'h2E, 0);
    acc(1, 0, 3, 6'h04, 0);
    // R11 all irqs
    ch_irq = 3'b111; acc(1, 0, 2, 6'h30, 0);
    ch_irq = 3'b000; acc(1, 0, 2, 6'h30, 0);
    // R7 cold write keeps 0x70 bits, clears semaphore
    acc(1, 1, 2, 6'h2C, 32'hFFFF_FFF5);
    acc(1, 0, 0, 6'h34, 0);
    acc(1, 1, 2, 6'h2C, 32'h0000_0012);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0]  a;
      logic [31:0] d;
      shuffle_ch();
      a = ($urandom % 4 == 0) ? 6'(($urandom % 3) * 16 + ($urandom % 12))
                              : 6'($urandom);
      if ($urandom % 6 == 0) a = 6'h2C;
      d = $urandom;
      if (a == 6'h2C && ($urandom % 8) != 0) d[1] = 1'b1;
      acc($urandom % 8 != 0, 1'($urandom), 2'($urandom % 4 == 3 ? 2 : $urandom % 3), a, d);
    end
    acc(0, 0, 0, 6'h00, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule